// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This controller takes a one-cycle sleep request that carries a mode index and works out which clock domains and which clock sources stay on while the system rests. The domains are the CPU, the high-speed bus and two peripheral buses. The sources are two main oscillators, two PLLs, a 32 kHz oscillator, an RC oscillator and a combined bandgap/brown-out enable. It does not stop the CPU while a CPU bus operation is still in flight. Once the bus is quiet, it applies the gating set for the chosen depth. It then watches a vector of pending wake events and reacts only to the sources that the active depth allows.

There are six depths, from shallow to deep. Each one stops more than the one before, and each accepts fewer wake sources. On wake, the stopped sources are switched back on first. The domain clocks stay gated until the oscillator-ready input confirms that the sources are stable. The controller then releases the clocks and raises a one-cycle completion pulse. Oscillator start-up, the analog parts and the interrupt controller are outside this block; they appear here only as enables and inputs.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: After reset, dom_clk_en equals clk_mask, every osc_en bit is 1 except bit 4 (which equals osc32_cfg), and wake_done is 0.
- R2: A request moves the controller to a drain phase at the next clock edge. Gating takes effect only after a clock edge at which bus_busy is low. While bus_busy stays high, no domain or source is gated.
- R3: Mode index 0 (Idle) gates only the CPU domain (dom bit 0) and stops no source. Any wake_pend bit wakes it.
- R4: Mode index 1 (Frozen) gates the CPU and high-speed bus domains (dom bits 0 and 1) and stops no source. Only wake bits 1 (peripheral-bus interrupt), 2 (timer event), 3 (external interrupt) and 4 (asynchronous external interrupt) wake it; bit 0 (CPU-side interrupt) does not.
- R5: Mode index 2 (Standby) gates all four domains and stops no source. Only wake bits 2, 3 and 4 wake it.
- R6: Mode index 3 (Stop) gates all domains and stops osc_en bits 0 to 3 (both main oscillators and both PLLs). Bit 4 keeps following osc32_cfg, and bits 5 and 6 stay on. Wake bits 2, 3, 4 and 5 (reset pin) wake it.
- R7: Mode index 4 (DeepStop) is like Stop and also clears osc_en bit 6 (bandgap/brown-out). Its wake sources are the same as Stop's.
- R8: Mode index 5 (Static) gates all domains and clears all seven osc_en bits. Only wake bits 4 and 5 wake it.
- R9: Any mode index above 5 behaves exactly as Idle.
- R10: While asleep, the domains that the mode stops read 0 in dom_clk_en whatever clk_mask holds. Domains that the mode does not stop follow clk_mask.
- R11: On an allowed wake, all sources are enabled at the next edge while the stopped domains stay gated. If the mode stopped any source, the domains stay gated until an edge at which osc_ready is high. The domains are then released in the same cycle as a wake_done pulse that lasts exactly one cycle.
- R12: A sleep request made while not running (drain, asleep or restoring) is ignored and does not change the active mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | One-cycle request to enter sleep |
| sleep_mode | input | MODE_W | Requested depth index, sampled with sleep_req |
| bus_busy | input | 1 | CPU bus has operations outstanding |
| wake_pend | input | 6 | Pending wake events: 0 CPU-side irq, 1 peripheral irq, 2 timer, 3 external irq, 4 async external irq, 5 reset pin |
| osc_ready | input | 1 | Restarted sources are stable |
| clk_mask | input | 4 | Run-time per-domain clock mask (0 CPU, 1 high-speed bus, 2 and 3 peripheral buses) |
| osc32_cfg | input | 1 | 32 kHz oscillator configured on |
| dom_clk_en | output | 4 | Domain clock enables, same bit order as clk_mask |
| osc_en | output | 7 | Source enables: 0 osc0, 1 osc1, 2 pll0, 3 pll1, 4 32 kHz, 5 RC, 6 bandgap/brown-out |
| wake_done | output | 1 | One-cycle pulse when normal clocks are back |

## Verification
Two functions can fall in the same cycle: the drain completing and a wake event arriving. The bench provokes this by raising an allowed wake bit in the same cycle that bus_busy falls. It judges the outcome by requiring that gating still appears for one cycle before the restore phase begins, so a pending wake never lets the controller skip the drain. A second collision, a new sleep request arriving while the controller is asleep, is judged by checking that the gating of the mode already in force does not change.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam int N_DOM  = 4;
    localparam int N_OSC  = 7;
    localparam int N_WAKE = 6;
    localparam int N_MODE = 6;
    localparam int MIDX_W = $clog2(N_MODE);

    typedef enum logic [MIDX_W-1:0] {
        M_IDLE     = 3'd0,
        M_FROZEN   = 3'd1,
        M_STANDBY  = 3'd2,
        M_STOP     = 3'd3,
        M_DEEPSTOP = 3'd4,
        M_STATIC   = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        S_RUN,
        S_DRAIN,
        S_SLEEP,
        S_RESTORE
    } state_e;

    typedef struct packed {
        logic [N_DOM-1:0]  dom_stop;
        logic [N_OSC-1:0]  osc_stop;
        logic [N_WAKE-1:0] wake_ok;
    } policy_t;

    typedef struct packed {
        state_e state;
        mode_e  mode;
        logic   done;
    } fsm_t;

endpackage

// File: rtl/slp_policy.sv
module slp_policy
    import slp_pkg::*;
(
    input  mode_e   mode,
    output policy_t pol
);
    always_comb begin
        pol = '0;
        case (mode)
            M_IDLE: begin
                pol.dom_stop = 4'b0001;
                pol.wake_ok  = 6'b111111;
            end
            M_FROZEN: begin
                pol.dom_stop = 4'b0011;
                pol.wake_ok  = 6'b011110;
            end
            M_STANDBY: begin
                pol.dom_stop = 4'b1111;
                pol.wake_ok  = 6'b011100;
            end
            M_STOP: begin
                pol.dom_stop = 4'b1111;
                pol.osc_stop = 7'b0001111;
                pol.wake_ok  = 6'b111100;
            end
            M_DEEPSTOP: begin
                pol.dom_stop = 4'b1111;
                pol.osc_stop = 7'b1001111;
                pol.wake_ok  = 6'b111100;
            end
            M_STATIC: begin
                pol.dom_stop = 4'b1111;
                pol.osc_stop = 7'b1111111;
                pol.wake_ok  = 6'b110000;
            end
            default: begin
                pol.dom_stop = 4'b0001;
                pol.wake_ok  = 6'b111111;
            end
        endcase
    end
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
#(
    parameter int MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              bus_busy,
    input  logic [N_WAKE-1:0] wake_pend,
    input  logic              osc_ready,
    input  policy_t           pol,
    output state_e            state,
    output mode_e             mode,
    output logic              done
);
    fsm_t  r_q, r_d;
    mode_e req_dec;
    logic  wake_hit;

    always_comb begin
        if (req_mode > MODE_W'(N_MODE - 1)) req_dec = M_IDLE;
        else                                req_dec = mode_e'(req_mode[MIDX_W-1:0]);
    end

    assign wake_hit = |(wake_pend & pol.wake_ok);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            S_RUN: begin
                if (sleep_req) begin
                    r_d.state = S_DRAIN;
                    r_d.mode  = req_dec;
                end
            end
            S_DRAIN: begin
                if (!bus_busy) r_d.state = S_SLEEP;
            end
            S_SLEEP: begin
                if (wake_hit) r_d.state = S_RESTORE;
            end
            S_RESTORE: begin
                if (osc_ready || (pol.osc_stop == '0)) begin
                    r_d.state = S_RUN;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = S_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_RUN, mode: M_IDLE, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.state;
    assign mode  = r_q.mode;
    assign done  = r_q.done;

    AST_ENTRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_SLEEP && $past(r_q.state) == S_DRAIN) |-> !$past(bus_busy)); // R2

    AST_STAY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_SLEEP && ((wake_pend & pol.wake_ok) == '0)) |=> (r_q.state == S_SLEEP)); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done); // R11

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != S_RUN && $past(r_q.state) != S_RUN) |-> $stable(r_q.mode)); // R12
endmodule

// File: rtl/slp_enables.sv
module slp_enables
    import slp_pkg::*;
(
    input  state_e           state,
    input  policy_t          pol,
    input  logic [N_DOM-1:0] clk_mask,
    input  logic             osc32_cfg,
    output logic [N_DOM-1:0] dom_clk_en,
    output logic [N_OSC-1:0] osc_en
);
    logic [N_DOM-1:0] dom_gate;
    logic [N_OSC-1:0] osc_gate;
    logic [N_OSC-1:0] osc_base;

    always_comb begin
        dom_gate = '0;
        osc_gate = '0;
        if (state == S_SLEEP || state == S_RESTORE) dom_gate = pol.dom_stop;
        if (state == S_SLEEP)                       osc_gate = pol.osc_stop;
        osc_base    = '1;
        osc_base[4] = osc32_cfg;
    end

    assign dom_clk_en = clk_mask & ~dom_gate;
    assign osc_en     = osc_base & ~osc_gate;
endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
    import slp_pkg::*;
#(
    parameter int MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic [MODE_W-1:0] sleep_mode,
    input  logic              bus_busy,
    input  logic [N_WAKE-1:0] wake_pend,
    input  logic              osc_ready,
    input  logic [N_DOM-1:0]  clk_mask,
    input  logic              osc32_cfg,
    output logic [N_DOM-1:0]  dom_clk_en,
    output logic [N_OSC-1:0]  osc_en,
    output logic              wake_done
);
    state_e  state;
    mode_e   mode;
    policy_t pol;

    slp_policy u_policy (
        .mode (mode),
        .pol  (pol)
    );

    slp_fsm #(.MODE_W(MODE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .req_mode  (sleep_mode),
        .bus_busy  (bus_busy),
        .wake_pend (wake_pend),
        .osc_ready (osc_ready),
        .pol       (pol),
        .state     (state),
        .mode      (mode),
        .done      (wake_done)
    );

    slp_enables u_en (
        .state      (state),
        .pol        (pol),
        .clk_mask   (clk_mask),
        .osc32_cfg  (osc32_cfg),
        .dom_clk_en (dom_clk_en),
        .osc_en     (osc_en)
    );

    AST_CPU_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SLEEP) |-> !dom_clk_en[0]); // R10

    AST_OSC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_done && $past(pol.osc_stop) != '0) |-> $past(osc_ready)); // R11

    AST_NO_GATE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN || state == S_DRAIN) |-> (dom_clk_en == clk_mask)); // R2
endmodule

// File: tb/tb_sleep_clk_ctrl.sv
module tb_sleep_clk_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic [7:0] sleep_mode = '0;
    logic       bus_busy = 1'b0;
    logic [5:0] wake_pend = '0;
    logic       osc_ready = 1'b0;
    logic [3:0] clk_mask = 4'hF;
    logic       osc32_cfg = 1'b1;
    logic [3:0] dom_clk_en;
    logic [6:0] osc_en;
    logic       wake_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sleep_clk_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_mode(sleep_mode),
        .bus_busy(bus_busy), .wake_pend(wake_pend), .osc_ready(osc_ready),
        .clk_mask(clk_mask), .osc32_cfg(osc32_cfg), .dom_clk_en(dom_clk_en),
        .osc_en(osc_en), .wake_done(wake_done)
    );

    function automatic logic [3:0] spec_dom(int m);
        case (m)
            0: return 4'b0001;
            1: return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [6:0] spec_osc(int m);
        case (m)
            3: return 7'b0001111;
            4: return 7'b1001111;
            5: return 7'b1111111;
            default: return 7'b0000000;
        endcase
    endfunction

    function automatic logic [6:0] osc_all();
        return {2'b11, osc32_cfg, 4'b1111};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 dom", 32'(dom_clk_en), 32'(clk_mask));
        chk("R1 osc", 32'(osc_en), 32'(osc_all()));
        chk("R1 done", 32'(wake_done), 0);
    endtask

    // enter mode m via code, try a disallowed wake, then an allowed one
    task automatic t_mode(string tag, int m, int code, logic [5:0] bad, logic [5:0] good);
        logic [3:0] gated;
        gated = clk_mask & ~spec_dom(m);
        sleep_mode = 8'(code); sleep_req = 1'b1;
        tick(); sleep_req = 1'b0;
        chk({tag, " drain dom"}, 32'(dom_clk_en), 32'(clk_mask));
        tick();
        chk({tag, " sleep dom"}, 32'(dom_clk_en), 32'(gated));
        chk({tag, " sleep osc"}, 32'(osc_en), 32'(osc_all() & ~spec_osc(m)));
        wake_pend = bad;
        tick();
        chk({tag, " ignore wake"}, 32'(dom_clk_en), 32'(gated));
        wake_pend = good;
        tick(); wake_pend = '0;
        chk({tag, " R11 osc first"}, 32'(osc_en), 32'(osc_all()));
        chk({tag, " R11 still gated"}, 32'(dom_clk_en), 32'(gated));
        chk({tag, " R11 no done yet"}, 32'(wake_done), 0);
        if (spec_osc(m) != 0) begin
            tick();
            chk({tag, " R11 wait ready"}, 32'(dom_clk_en), 32'(gated));
            osc_ready = 1'b1;
        end
        tick(); osc_ready = 1'b0;
        chk({tag, " R11 done"}, 32'(wake_done), 1);
        chk({tag, " R11 released"}, 32'(dom_clk_en), 32'(clk_mask));
        tick();
        chk({tag, " R11 pulse end"}, 32'(wake_done), 0);
    endtask

    task automatic t_drain();
        bus_busy = 1'b1; sleep_mode = 8'd2; sleep_req = 1'b1;
        tick(); sleep_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R2 held", 32'(dom_clk_en), 32'(clk_mask));
        end
        bus_busy = 1'b0; wake_pend = 6'b000100;
        tick();
        chk("R2 entered despite wake", 32'(dom_clk_en), 0);
        tick(); wake_pend = '0;
        chk("R2 restore dom", 32'(dom_clk_en), 0);
        tick();
        chk("R2 back", 32'(dom_clk_en), 32'(clk_mask));
        chk("R2 done", 32'(wake_done), 1);
        tick();
    endtask

    task automatic t_ignore_req();
        sleep_mode = 8'd1; sleep_req = 1'b1;
        tick(); sleep_req = 1'b0;
        tick();
        chk("R12 frozen dom", 32'(dom_clk_en), 32'(4'b1100));
        sleep_mode = 8'd5; sleep_req = 1'b1;
        tick(); sleep_req = 1'b0;
        chk("R12 mode kept dom", 32'(dom_clk_en), 32'(4'b1100));
        chk("R12 mode kept osc", 32'(osc_en), 32'(osc_all()));
        wake_pend = 6'b000010;
        tick(); wake_pend = '0;
        tick();
        chk("R12 woke as frozen", 32'(wake_done), 1);
        tick();
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_mode("R3 idle", 0, 0, 6'b000000, 6'b000001);
        t_mode("R4 frozen", 1, 1, 6'b000001, 6'b000010);
        t_mode("R5 standby", 2, 2, 6'b000011, 6'b000100);
        t_mode("R6 stop", 3, 3, 6'b000011, 6'b100000);
        t_mode("R7 deepstop", 4, 4, 6'b000011, 6'b001000);
        t_mode("R8 static", 5, 5, 6'b001111, 6'b010000);
        t_mode("R9 code7", 0, 7, 6'b000000, 6'b000010);
        t_mode("R9 code200", 0, 200, 6'b000000, 6'b100000);
        osc32_cfg = 1'b0;
        t_mode("R6 stop no32k", 3, 3, 6'b000001, 6'b000100);
        osc32_cfg = 1'b1;
        clk_mask = 4'b1010;
        tick();
        chk("R10 run mask", 32'(dom_clk_en), 32'(4'b1010));
        t_mode("R10 frozen masked", 1, 1, 6'b000001, 6'b000010);
        clk_mask = 4'b1111;
        tick();
        t_drain();
        t_ignore_req();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule